// File: doc/BRIEF.md
# Composite Sync Vertical Pulse Separator

This block pulls a clean vertical sync flag out of a digital composite sync stream that carries both line and frame sync. The horizontal pulses and equalization pulses are short and the vertical interval is long. A single saturating 8-bit up/down counter advances only on a slow timebase enable tick and measures how long the composite sync level stays active. The count is compared against a programmable threshold. Short pulses leave the count below the threshold and are rejected. A long pulse drives the count past the threshold and raises the flag.

Once the flag is up, the counter restarts from zero and measures the inactive time instead. Active ticks inside the vertical interval, such as serration pulses, pause this measurement but do not restart it. The flag drops when the inactive time reaches the same threshold. Each output edge therefore trails the real vertical sync edge by about the threshold duration. A typical tick period is 200 ns, so a threshold of N stands for N × 200 ns.

The composite sync input is asynchronous. It is brought into the clock domain through a two-flop synchronizer. A polarity input then chooses whether the high level or the low level counts as active.

Top module: `csync_vsep`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter clears to 0 and `vsync_out` goes to 0.
- R2: `csync_in` passes through two flops before counting. A level applied just after a clock edge is first counted by a tick at the third rising edge after the change. With `csync_inv` = 0 a high level is active. With `csync_inv` = 1 a low level is active.
- R3: While `vsync_out` is 0, each clock with `tick_en` = 1 adds 1 to the count if sync is active. If sync is inactive, it subtracts 1, but the count never goes below 0. Clocks with `tick_en` = 0 change nothing.
- R4: While `vsync_out` is 0, `vsync_out` rises on the active tick that would take the count above `thresh`. With `thresh` = T, this is the (T+1)-th net active tick. On that tick the counter clears to 0. With `thresh` = 0, a single active tick is enough.
- R5: A pulse of at most `thresh` active ticks never raises `vsync_out`, even when such pulses repeat, as long as the inactive gaps between them drain the count.
- R6: While `vsync_out` is 1, each inactive tick adds 1 to the count. `vsync_out` falls on the inactive tick that brings the count to `thresh`, and the counter clears to 0.
- R7: While `vsync_out` is 1, an active tick holds the count. It neither releases the flag nor restarts the inactive measurement.
- R8: The count saturates at 255 and never wraps. With `thresh` = 255, `vsync_out` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timebase enable, one clock wide per count step |
| csync_in | input | 1 | Composite sync level, asynchronous |
| csync_inv | input | 1 | 1: low level is active; 0: high level is active |
| thresh | input | 8 | Threshold in ticks, used for both detection and release |
| vsync_out | output | 1 | Separated vertical sync flag |

## Verification
On every cycle the assertions check the following:
- the counter and flag stay frozen on clocks without a tick;
- the count holds at zero on inactive ticks while hunting, and holds at 255 on active ticks instead of wrapping;
- every rise of the flag follows an active tick and leaves the count at zero;
- every fall of the flag follows an inactive tick;
- an active tick during the vertical interval keeps both the flag and the count unchanged.

Only the directed scenarios can show the exact tick on which each edge appears for a given threshold. The same holds for the two-flop input latency, the polarity inversion, the rejection of repeated short pulses, and the fact that a saturated count drains from 255 rather than from a wrapped value.

// File: rtl/vsep_pkg.sv
// Shared types for the composite sync vertical separator.
package vsep_pkg;

    // Operation requested from the pulse-width counter for one clock.
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_DEC  = 2'd2,
        CNT_CLR  = 2'd3
    } cnt_op_e;

    // Measurement phase: hunting for a long active pulse, or timing the
    // inactive period that ends the vertical interval.
    typedef enum logic {
        PH_HUNT    = 1'b0,
        PH_RELEASE = 1'b1
    } phase_e;

endpackage

// File: rtl/vsep_insync.sv
// Input conditioner.
// Brings the asynchronous composite sync level into the clock domain
// through a chain of STAGES flops, then applies the polarity select.
// Assumes: STAGES >= 2. The polarity select is quasi-static and is
// applied after the chain, so a change of polarity takes effect at once.
module vsep_insync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic invert,
    output logic active
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First capture flop of the synchronizer.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= raw_in;
                end
            end else begin : g_next
                // Further resolution flop of the synchronizer.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    // Map the synchronized level onto "active" using the polarity select.
    always_comb begin
        active = chain_q[STAGES-1] ^ invert;
    end

endmodule

// File: rtl/vsep_updown.sv
// Saturating pulse-width counter.
// Executes one operation per clock as requested by the phase controller.
// It also exposes the saturated next-up value so the controller can
// compare it against the threshold without a second adder.
// Assumes: the controller only requests a change on tick clocks.
module vsep_updown
    import vsep_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_up
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_dn;

    // Saturating increment and floored decrement of the stored count.
    always_comb begin
        cnt_up = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + CNT_ONE;
        cnt_dn = (cnt_q == '0)      ? '0      : cnt_q - CNT_ONE;
    end

    // Count register: apply the requested operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (op)
                CNT_INC:  cnt_q <= cnt_up;
                CNT_DEC:  cnt_q <= cnt_dn;
                CNT_CLR:  cnt_q <= '0;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/vsep_phase_ctl.sv
// Phase controller.
// Decides the counter operation on each tick and owns the phase flop.
// The phase flop is the vertical sync flag.
//   Hunt phase:    an active tick counts up, an inactive tick counts down.
//                  An active tick whose next value exceeds the threshold
//                  enters the release phase and clears the counter.
//   Release phase: an inactive tick counts up, an active tick holds.
//                  An inactive tick whose next value reaches the threshold
//                  returns to the hunt phase and clears the counter.
// Assumes: cnt_up is the saturated increment of the current count.
module vsep_phase_ctl
    import vsep_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic [CNT_W-1:0] thresh,
    input  logic [CNT_W-1:0] cnt_up,
    output cnt_op_e          op,
    output logic             in_release
);

    phase_e phase_q;
    phase_e phase_d;

    // Next-phase and counter-operation decision for this clock.
    always_comb begin
        phase_d = phase_q;
        op      = CNT_HOLD;
        if (tick) begin
            unique case (phase_q)
                PH_HUNT: begin
                    if (active) begin
                        if (cnt_up > thresh) begin
                            op      = CNT_CLR;
                            phase_d = PH_RELEASE;
                        end else begin
                            op      = CNT_INC;
                        end
                    end else begin
                        op = CNT_DEC;
                    end
                end
                PH_RELEASE: begin
                    if (!active) begin
                        if (cnt_up >= thresh) begin
                            op      = CNT_CLR;
                            phase_d = PH_HUNT;
                        end else begin
                            op      = CNT_INC;
                        end
                    end
                end
                default: phase_d = PH_HUNT;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_HUNT;
        else        phase_q <= phase_d;
    end

    assign in_release = (phase_q == PH_RELEASE);

endmodule

// File: rtl/csync_vsep.sv
// Composite sync vertical separator, top level.
// Synchronizes the composite sync input, applies the polarity select and
// measures pulse widths on timebase ticks. It raises vsync_out for long
// active pulses and drops it after an inactive period of the same length.
// Assumes: tick_en is one clock wide per timebase step; thresh may change
// at any time and is used as seen on each tick.
module csync_vsep #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             csync_in,
    input  logic             csync_inv,
    input  logic [CNT_W-1:0] thresh,
    output logic             vsync_out
);

    import vsep_pkg::*;

    logic             cs_active;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_up;
    cnt_op_e          cnt_op;

    vsep_insync #(.STAGES(SYNC_STAGES)) u_insync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (csync_in),
        .invert (csync_inv),
        .active (cs_active)
    );

    vsep_updown #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (cnt_op),
        .cnt    (cnt_q),
        .cnt_up (cnt_up)
    );

    vsep_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_en),
        .active     (cs_active),
        .thresh     (thresh),
        .cnt_up     (cnt_up),
        .op         (cnt_op),
        .in_release (vsync_out)
    );

endmodule

// File: rtl/vsep_chk.sv
// Checker for csync_vsep: cycle-level properties of counter and flag.
module vsep_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cs_active,
    input logic [CNT_W-1:0] cnt,
    input logic             vsync
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // R3: no tick, no change of count or flag.
    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> ($stable(cnt) && $stable(vsync)));

    // R3: inactive tick while hunting at zero keeps zero.
    assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !cs_active && !vsync && cnt == '0) |=> (cnt == '0));

    // R4: a rising flag follows an active tick and leaves a cleared count.
    assert_rise_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> ($past(tick_en && cs_active) && cnt == '0));

    // R6: a falling flag follows an inactive tick and leaves a cleared count.
    assert_fall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync) |-> ($past(tick_en && !cs_active) && cnt == '0));

    // R7: active tick during the vertical interval holds flag and count.
    assert_serr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cs_active && vsync) |=> (vsync && $stable(cnt)));

    // R8: an active tick at full count while hunting never wraps.
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cs_active && !vsync && cnt == CNT_MAX) |=> (cnt == CNT_MAX || vsync));

endmodule

bind csync_vsep vsep_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .cs_active (cs_active),
    .cnt       (cnt_q),
    .vsync     (vsync_out)
);

// File: tb/csync_vsep_tb.sv
// Directed bench for csync_vsep: one task per scenario.
module csync_vsep_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       csync_in = 1'b0;
    logic       csync_inv = 1'b0;
    logic [7:0] thresh = 8'd5;
    logic       vsync_out;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csync_vsep u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .csync_in  (csync_in),
        .csync_inv (csync_inv),
        .thresh    (thresh),
        .vsync_out (vsync_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: vsync_out actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Reset with a given threshold and polarity; raw input left low.
    task automatic do_reset(input logic [7:0] t, input logic inv);
        @(negedge clk);
        rst_n = 1'b0; tick_en = 1'b0; csync_in = 1'b0;
        thresh = t; csync_inv = inv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Apply a raw level, let it settle through the synchronizer, then
    // give n back-to-back ticks. Returns on a falling edge.
    task automatic run_level(input logic lvl, input int n);
        @(negedge clk);
        csync_in = lvl; tick_en = 1'b0;
        repeat (2) @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        do_reset(8'd5, 1'b0);
        check("R1 reset", vsync_out, 1'b0);
    endtask

    task automatic t_short_pulses;
        do_reset(8'd5, 1'b0);
        for (int i = 0; i < 5; i++) begin
            run_level(1'b1, 5);
            check("R5 short pulse", vsync_out, 1'b0);
            run_level(1'b0, 5);
        end
    endtask

    task automatic t_accumulate;
        do_reset(8'd5, 1'b0);
        run_level(1'b1, 3);
        run_level(1'b0, 1);
        run_level(1'b1, 3);
        check("R3 net count 5", vsync_out, 1'b0);
        run_level(1'b1, 1);
        check("R4 net count 6 detects", vsync_out, 1'b1);
        run_level(1'b0, 4);
        check("R6 four inactive ticks hold", vsync_out, 1'b1);
        run_level(1'b0, 1);
        check("R6 fifth inactive tick releases", vsync_out, 1'b0);
    endtask

    task automatic t_serration;
        do_reset(8'd5, 1'b0);
        run_level(1'b1, 5);
        check("R4 five active ticks", vsync_out, 1'b0);
        run_level(1'b1, 1);
        check("R4 sixth active tick", vsync_out, 1'b1);
        run_level(1'b1, 100);
        check("R7 long active keeps flag", vsync_out, 1'b1);
        run_level(1'b0, 4);
        run_level(1'b1, 2);
        check("R7 serration keeps flag", vsync_out, 1'b1);
        run_level(1'b0, 1);
        check("R7 count held across serration", vsync_out, 1'b0);
    endtask

    task automatic t_floor;
        do_reset(8'd5, 1'b0);
        run_level(1'b0, 10);
        run_level(1'b1, 5);
        check("R3 floor at zero", vsync_out, 1'b0);
        run_level(1'b1, 1);
        check("R3 detect after floor", vsync_out, 1'b1);
    endtask

    task automatic t_no_tick;
        do_reset(8'd5, 1'b0);
        @(negedge clk);
        csync_in = 1'b1;
        repeat (50) @(negedge clk);
        check("R3 no tick no count", vsync_out, 1'b0);
        run_level(1'b1, 5);
        check("R3 idle clocks did not count", vsync_out, 1'b0);
        run_level(1'b1, 1);
        check("R3 detect on ticks only", vsync_out, 1'b1);
    endtask

    task automatic t_polarity;
        do_reset(8'd5, 1'b1);
        run_level(1'b1, 20);
        check("R2 high is inactive when inverted", vsync_out, 1'b0);
        run_level(1'b0, 6);
        check("R2 low is active when inverted", vsync_out, 1'b1);
        run_level(1'b1, 5);
        check("R2 inverted release", vsync_out, 1'b0);
    endtask

    task automatic t_latency;
        do_reset(8'd5, 1'b0);
        @(negedge clk);
        csync_in = 1'b1; tick_en = 1'b1;
        repeat (7) @(negedge clk);
        tick_en = 1'b0;
        check("R2 first two ticks see old level", vsync_out, 1'b0);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        check("R2 sixth active tick after latency", vsync_out, 1'b1);
    endtask

    task automatic t_saturate;
        do_reset(8'd255, 1'b0);
        run_level(1'b1, 300);
        check("R8 threshold 255 never detects", vsync_out, 1'b0);
        run_level(1'b0, 250);
        @(negedge clk);
        thresh = 8'd4;
        run_level(1'b1, 1);
        check("R8 count saturated not wrapped", vsync_out, 1'b1);
    endtask

    task automatic t_zero_thresh;
        do_reset(8'd0, 1'b0);
        run_level(1'b1, 1);
        check("R4 threshold 0 single tick", vsync_out, 1'b1);
        run_level(1'b0, 1);
        check("R6 threshold 0 single tick release", vsync_out, 1'b0);
    endtask

    initial begin
        t_reset();
        t_short_pulses();
        t_accumulate();
        t_serration();
        t_floor();
        t_no_tick();
        t_polarity();
        t_latency();
        t_saturate();
        t_zero_thresh();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: done actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule